// File: doc/BRIEF.md
# Byte-to-Serial Line Transmitter

This block turns a stream of parallel bytes into a single bit-serial stream for an STS-3 or STS-12 optical line interface. It runs on a fast clock and takes a one-bit-per-cycle enable. Each enabled cycle is one bit period on the line. From that bit timing the block makes a byte-rate clock, `byte_clk`, for the upstream logic to run on. It also makes an internal load strobe that is locked in phase to that byte clock.

Each byte passes through two registers. A holding register samples the parallel bus at the rising edge of the byte clock. A parallel-loadable shift register then takes the held byte on the load strobe and sends it out most significant bit first. Upstream logic clocked by `byte_clk` therefore always meets the transfer timing. The shifted bit drives two redundant serial copies, and each copy has its own output enable.

Top module: `byte_serializer_tx`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `byte_clk` and every `ser_out` bit are 0. Asserting reset in the middle of a stream restarts the bit timing from zero.
- R2: In a cycle with `bit_en` low, no state changes: `byte_clk` and `ser_out` keep their values, whatever `par_data` holds.
- R3: Count the enabled bit cycles since reset, starting at 0. `byte_clk` is low while the count modulo 8 is 0 to 3 and high while it is 4 to 7. This gives a period of 8 bit cycles.
- R4: The holding register samples `par_data` in the enabled bit cycle whose count modulo 8 is 3. The sampled value is the one present at the edge where `byte_clk` rises.
- R5: Bits are sent most significant bit first. Byte n is the byte sampled in the n-th capture, counting from 0. After enabled cycle count T with T >= 8, the line carries bit 7-(T mod 8) of byte (T-8)/8.
- R6: The load strobe fires exactly once per 8 enabled bit cycles, in the cycle whose count modulo 8 is 7, while `byte_clk` is high. That is the cycle in which the last bit of the previous byte is on the line, so consecutive bytes leave with no gap.
- R7: Until the first load, which happens after 8 enabled cycles, the line carries 0.
- R8: `ser_out[i]` follows the serial line when `ser_oe[i]` is 1 and is 0 when `ser_oe[i]` is 0. Each copy is independent of the other copy's enable, and the enables do not disturb the data stream.
- R9: Values on `par_data` outside the capture cycle of R4 have no effect on the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One serial bit period per cycle in which it is high |
| par_data | input | 8 | Parallel byte from upstream logic |
| ser_oe | input | 2 | Per-copy output enable |
| byte_clk | output | 1 | Byte-rate clock derived from bit timing |
| ser_out | output | 2 | Redundant serial output copies |

## Verification
The embedded assertions check, on every cycle, the following:
- the freeze of all state when no bit period is enabled;
- the rise of `byte_clk` right after a capture;
- the load strobe falling in the high half of the byte clock and restarting the count;
- the line staying at zero before the first load;
- the enabled copies agreeing with each other.

Only the bench scenarios can show the actual ordering of bits on the line, the back-to-back continuity across bytes, and the immunity to bus changes outside the capture edge. To do this, the bench streams all 256 byte values under both a continuous enable and an irregular enable.

// File: rtl/byte_serializer_tx.sv
module byte_serializer_tx #(
  parameter int WIDTH  = 8,
  parameter int COPIES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [WIDTH-1:0]  par_data,
  input  logic [COPIES-1:0] ser_oe,
  output logic              byte_clk,
  output logic [COPIES-1:0] ser_out
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] CAP_AT = CW'(WIDTH/2 - 1);
  localparam logic [CW-1:0] LAST   = CW'(WIDTH - 1);
  localparam logic [CW-1:0] HALF   = CW'(WIDTH/2);

  logic [CW-1:0]    bit_cnt;
  logic [WIDTH-1:0] hold_q, shift_q;
  logic             loaded_q;

  wire load_stb = bit_en && (bit_cnt == LAST);
  wire cap_stb  = bit_en && (bit_cnt == CAP_AT);

  assign byte_clk = (bit_cnt >= HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bit_cnt <= '0;
    else if (bit_en) bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (cap_stb) hold_q <= par_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      loaded_q <= 1'b0;
    end else if (load_stb) begin
      shift_q  <= hold_q;
      loaded_q <= 1'b1;
    end else if (bit_en) begin
      shift_q  <= {shift_q[WIDTH-2:0], 1'b0};
    end
  end

  // R3
  bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(byte_clk));
  // R2
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(shift_q) && $stable(hold_q)));
  // R4
  cap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> $rose(byte_clk));
  // R6
  load_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> byte_clk);
  // R6
  load_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (!byte_clk && bit_cnt == '0));
  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_q |-> (shift_q == '0));

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    assign ser_out[i] = ser_oe[i] & shift_q[WIDTH-1];
    // R8
    copy_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_oe[i] && ser_oe[0]) |-> (ser_out[i] == ser_out[0]));
  end
endmodule

// File: tb/byte_serializer_tx_test.sv
module byte_serializer_tx_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bit_en = 0;
  logic [7:0] par_data = 0;
  logic [1:0] ser_oe = 2'b11;
  logic       byte_clk;
  logic [1:0] ser_out;

  int errors = 0, checks = 0;
  int ticks = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  byte_serializer_tx uut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .par_data(par_data), .ser_oe(ser_oe), .byte_clk(byte_clk), .ser_out(ser_out));

  function automatic logic [7:0] byte_of(int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  function automatic logic line_bit(int t);
    logic [7:0] b;
    if (t < 8) return 1'b0;
    b = byte_of((t - 8) / 8);
    return b[7 - (t % 8)];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%h expected=%h", tag, ticks, act, exp);
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // one cycle: drive at negedge, advance, check after the edge
  task automatic step(logic en);
    logic lb;
    next_rand();
    bit_en = en;
    ser_oe = lfsr[3:2] | {2{lfsr[7]}};
    // R4 capture value only at count 3 with enable; R9 garbage otherwise
    par_data = (en && (ticks % 8 == 3)) ? byte_of(ticks / 8) : ~lfsr[15:8];
    @(posedge clk);
    if (en) ticks++;
    @(negedge clk);
    lb = line_bit(ticks);
    chk("R3 byte_clk", {7'd0, byte_clk}, {7'd0, 1'b0 | ((ticks % 8) >= 4)});
    if (!en)
      chk("R2 R8 hold", {6'd0, ser_out}, {6'd0, ser_oe & {2{lb}}});
    else if (ticks < 8)
      chk("R7 R8 idle", {6'd0, ser_out}, 8'd0);
    else
      chk("R5 R6 R4 R9 R8 data", {6'd0, ser_out}, {6'd0, ser_oe & {2{lb}}});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    bit_en = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset byte_clk", {7'd0, byte_clk}, 8'd0);
    chk("R1 reset ser_out", {6'd0, ser_out}, 8'd0);
    rst_n = 1;
    bit_en = 0;
    ticks = 0;
    @(negedge clk);
    chk("R1 post byte_clk", {7'd0, byte_clk}, 8'd0);
    chk("R1 post ser_out", {6'd0, ser_out}, 8'd0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    // continuous enable, all 256 byte values
    while (ticks < 8 * 258) step(1'b1);
    // mid-stream reset, then irregular enable
    for (int k = 0; k < 13; k++) step(1'b1);
    do_reset();
    while (ticks < 8 * 258) step(lfsr[0] | lfsr[5]);
    // long stall right at the load cycle
    while (ticks % 8 != 7) step(1'b1);
    for (int k = 0; k < 5; k++) step(1'b0);
    for (int k = 0; k < 16; k++) step(1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule